// File: doc/BRIEF.md
# Mid-Phase Chip Timing Error Detector

This block is the detector stage of a chip tracking loop for a binary ranging signal. It takes a real baseband sample stream that carries a fixed, even number of samples per chip (eight by default) and, for every chip, produces two numbers: an in-phase value and a timing error value. The in-phase value is the sum of all samples of one chip, which is the area of the chip pulse. The timing error is an integral over one chip period that straddles a chip boundary. The half before the boundary is subtracted and the half after it is added. Each error is then multiplied by a sign that alternates from chip to chip, which partly cancels the effect of the unknown code.

A chip strobe from the loop's interpolator control marks the sample that opens a chip. The first strobe after reset locks the detector. A later strobe that lands on a sample other than the expected chip start realigns the chip grid. The loop filter and the interpolator sit outside this block. Input scaling is assumed to be done upstream, because the slope of the error depends only on the power of the ranging signal.

Top module: `chip_mid_ted`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `ip_vld` and `err_vld` are low. Reset clears both accumulators and sets the alternating sign so that the next error is emitted with sign +1.
- R2: Until the first sample that arrives with `chip_stb` high, samples are ignored and no output is produced.
- R3: The sample taken with `chip_stb` high is phase 0, and each following accepted sample advances the phase by one, modulo 8. In the cycle after the phase-7 sample is accepted, `ip_vld` is high for exactly one cycle and `ip_val` equals the sum of the samples of phases 0 to 7 of that chip.
- R4: In the cycle after a phase-3 sample is accepted, `err_vld` is high for one cycle. The raw error is the sum of phases 0 to 3 of the current chip minus the sum of phases 4 to 7 of the previous chip. An error is produced only when its window holds all eight samples, so it follows its `ip_vld` by four accepted samples.
- R5: The k-th error emitted after reset, counting from zero, is the raw error multiplied by +1 for even k and by −1 for odd k.
- R6: Full-scale inputs (−2048 and +2047 for 12-bit samples) never overflow `ip_val` or `err_val`. The outputs are 15-bit two's complement.
- R7: Cycles with `smp_vld` low advance nothing, and they neither add to nor split a window.
- R8: `chip_stb` is ignored in cycles where `smp_vld` is low.
- R9: A strobe on a sample whose expected phase is not 0 makes that sample phase 0. The partial in-phase window is dropped. The error window that spans the jump is discarded without emitting and without advancing the sign.
- R10: A strobe on a sample that is already expected to be phase 0 changes no output.
- R11: A reset during operation discards all windows. Outputs resume only after a new strobe, and the first error after that has sign +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input sample valid |
| smp_in | input | 12 | Signed input sample |
| chip_stb | input | 1 | Marks the sample that opens a chip |
| ip_vld | output | 1 | In-phase value valid, one cycle per chip |
| ip_val | output | 15 | Signed chip pulse area |
| err_vld | output | 1 | Error value valid, one cycle per chip |
| err_val | output | 15 | Signed, sign-alternated timing error |

## Verification
The hardest condition to reach is a realignment strobe that lands while an error window is half full. It must throw that window away without advancing the alternating sign, and the following windows must then line up again on the new grid. The stimulus places strobes at several mid-chip phases inside long random streams, with valid gaps around them. A bench model that counts half-window sums predicts exactly which chips may emit, so a dropped window or an extra sign flip shows up as a wrong sign on every later error. Full-scale directed chips, arranged so that the two halves of the error window have opposite extremes, exercise the accumulator width.

// File: rtl/chip_mid_ted_pkg.sv
package chip_mid_ted_pkg;

  // Step weight of the error window: the half before the chip boundary counts negative.
  function automatic int step_term(int x, logic before_boundary);
    return before_boundary ? -x : x;
  endfunction

  // Alternating code-sign correction applied to a finished error.
  function automatic int apply_polarity(int raw, logic negate);
    return negate ? -raw : raw;
  endfunction

  // Accumulate one term, restarting the window when asked.
  function automatic int accumulate(int acc, int term, logic restart);
    return restart ? term : acc + term;
  endfunction

endpackage

// File: rtl/ted_phase_ctr.sv
module ted_phase_ctr #(
  parameter int SPC  = 8,
  localparam int PH_W = $clog2(SPC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_vld,
  input  logic            chip_stb,
  output logic            take,
  output logic [PH_W-1:0] phase,
  output logic            slip
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SPC - 1);

  logic            locked_q;
  logic [PH_W-1:0] ph_q;

  assign take  = smp_vld && (locked_q || chip_stb);
  assign phase = chip_stb ? '0 : ph_q;
  assign slip  = smp_vld && chip_stb && locked_q && (ph_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      ph_q     <= '0;
    end else if (take) begin
      locked_q <= 1'b1;
      ph_q     <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/ted_inphase_acc.sv
module ted_inphase_acc
  import chip_mid_ted_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int SPC   = 8,
  localparam int PH_W  = $clog2(SPC),
  localparam int ACC_W = SMP_W + PH_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [PH_W-1:0]         phase,
  input  logic signed [SMP_W-1:0] smp,
  output logic                    vld,
  output logic signed [ACC_W-1:0] val
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SPC - 1);

  logic signed [ACC_W-1:0] acc_q;
  int sum_now;

  always_comb sum_now = accumulate(int'(acc_q), int'(smp), phase == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld   <= 1'b0;
      val   <= '0;
    end else begin
      vld <= 1'b0;
      if (take) begin
        acc_q <= ACC_W'(sum_now);
        if (phase == LAST) begin
          vld <= 1'b1;
          val <= ACC_W'(sum_now);
        end
      end
    end
  end
endmodule

// File: rtl/ted_error_acc.sv
module ted_error_acc
  import chip_mid_ted_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int SPC   = 8,
  localparam int PH_W  = $clog2(SPC),
  localparam int ACC_W = SMP_W + PH_W,
  localparam int HALF  = SPC / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [PH_W-1:0]         phase,
  input  logic                    slip,
  input  logic signed [SMP_W-1:0] smp,
  output logic                    vld,
  output logic signed [ACC_W-1:0] val,
  output logic                    neg
);
  localparam logic [PH_W-1:0] OPEN  = PH_W'(HALF);
  localparam logic [PH_W-1:0] CLOSE = PH_W'(HALF - 1);

  logic signed [ACC_W-1:0] acc_q;
  logic armed_q;
  logic opening, closing, before_bnd;
  int   term, sum_now;

  assign opening    = (phase == OPEN);
  assign closing    = (phase == CLOSE);
  assign before_bnd = (phase >= OPEN);

  always_comb begin
    term    = step_term(int'(smp), before_bnd);
    sum_now = accumulate(int'(acc_q), term, opening);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      armed_q <= 1'b0;
      neg     <= 1'b0;
      vld     <= 1'b0;
      val     <= '0;
    end else begin
      vld <= 1'b0;
      if (take) begin
        acc_q <= ACC_W'(sum_now);
        if (slip)         armed_q <= 1'b0;
        else if (opening) armed_q <= 1'b1;
        if (closing && armed_q && !slip) begin
          vld <= 1'b1;
          val <= ACC_W'(apply_polarity(sum_now, neg));
          neg <= ~neg;
        end
      end
    end
  end
endmodule

// File: rtl/chip_mid_ted.sv
module chip_mid_ted #(
  parameter int SMP_W = 12,
  parameter int SPC   = 8,
  localparam int PH_W  = $clog2(SPC),
  localparam int ACC_W = SMP_W + PH_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_in,
  input  logic                    chip_stb,
  output logic                    ip_vld,
  output logic signed [ACC_W-1:0] ip_val,
  output logic                    err_vld,
  output logic signed [ACC_W-1:0] err_val
);
  generate
    if ((SPC % 2) != 0 || SPC < 4 || (1 << PH_W) != SPC) begin : g_bad_spc
      $error("samples per chip must be an even power of two of at least four");
    end
  endgenerate

  logic            take, slip, err_neg;
  logic [PH_W-1:0] phase;

  ted_phase_ctr #(.SPC(SPC)) phase_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .chip_stb(chip_stb),
    .take(take), .phase(phase), .slip(slip)
  );

  ted_inphase_acc #(.SMP_W(SMP_W), .SPC(SPC)) ip_i (
    .clk(clk), .rst(rst), .take(take), .phase(phase), .smp(smp_in),
    .vld(ip_vld), .val(ip_val)
  );

  ted_error_acc #(.SMP_W(SMP_W), .SPC(SPC)) err_i (
    .clk(clk), .rst(rst), .take(take), .phase(phase), .slip(slip),
    .smp(smp_in), .vld(err_vld), .val(err_val), .neg(err_neg)
  );
endmodule

// File: rtl/chip_mid_ted_chk.sv
module chip_mid_ted_chk #(
  parameter int SMP_W = 12,
  parameter int SPC   = 8,
  localparam int ACC_W = SMP_W + $clog2(SPC)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_vld,
  input logic                    ip_vld,
  input logic                    err_vld,
  input logic signed [ACC_W-1:0] err_val,
  input logic                    err_neg
);
  localparam int HALF    = SPC / 2;
  localparam int ERR_MAX = HALF * (2 ** (SMP_W - 1)) + HALF * (2 ** (SMP_W - 1) - 1);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ip_vld && !err_vld)); // R1

  AST_IP_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    ip_vld |-> $past(smp_vld)); // R3

  AST_ERR_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> $past(smp_vld)); // R4

  AST_OUTPUTS_APART: assert property (@(posedge clk) disable iff (rst)
    !(ip_vld && err_vld)); // R4

  AST_SIGN_FLIPS: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> (err_neg != $past(err_neg))); // R5

  AST_SIGN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !err_vld |-> $stable(err_neg)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> (int'(err_val) <= ERR_MAX && int'(err_val) >= -ERR_MAX)); // R6
endmodule

bind chip_mid_ted chip_mid_ted_chk #(.SMP_W(SMP_W), .SPC(SPC)) chk_i (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .ip_vld(ip_vld),
  .err_vld(err_vld), .err_val(err_val), .err_neg(err_neg)
);

// File: tb/chip_mid_ted_tb_top.sv
module chip_mid_ted_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic chip_stb = 1'b0;
  logic signed [11:0] smp_in = '0;
  logic ip_vld, err_vld;
  logic signed [14:0] ip_val, err_val;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model state: half-window sums
  bit m_lock, m_neg, e_armed;
  int m_ph, ip_sum, e_before, e_after;

  always #4 clk = ~clk;

  chip_mid_ted dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in), .chip_stb(chip_stb),
    .ip_vld(ip_vld), .ip_val(ip_val), .err_vld(err_vld), .err_val(err_val)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd_smp();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  task automatic model_clear();
    m_lock = 0; m_neg = 0; e_armed = 0;
    m_ph = 0; ip_sum = 0; e_before = 0; e_after = 0;
  endtask

  // one cycle: drive at negedge, compare registered outputs at next negedge
  task automatic step(bit v, bit s, int x, string tag);
    bit xi = 0, xe = 0;
    int ei = 0, ee = 0;
    smp_vld = v; chip_stb = s; smp_in = 12'(x);
    if (v && (m_lock || s)) begin
      if (s) begin
        if (m_lock && m_ph != 0) e_armed = 0;
        m_ph = 0;
      end
      if (m_ph == 0) ip_sum = 0;
      ip_sum += x;
      if (m_ph == 7) begin xi = 1; ei = ip_sum; end
      if (m_ph == 4) begin e_before = 0; e_after = 0; e_armed = 1; end
      if (m_ph >= 4) e_before += x; else e_after += x;
      if (m_ph == 3 && e_armed) begin
        xe = 1;
        ee = m_neg ? (e_before - e_after) : (e_after - e_before);
        m_neg = !m_neg;
      end
      m_lock = 1;
      m_ph = (m_ph + 1) % 8;
    end
    @(negedge clk);
    if (xi || ip_vld) check(ip_vld == xi && (!xi || int'(ip_val) == ei),
                            {tag, " ip"}, xi ? int'(ip_val) : int'(ip_vld), xi ? ei : 0);
    if (xe || err_vld) check(err_vld == xe && (!xe || int'(err_val) == ee),
                             {tag, " err"}, xe ? int'(err_val) : int'(err_vld), xe ? ee : 0);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1; smp_vld = 0; chip_stb = 0;
    repeat (3) @(negedge clk);
    check(!ip_vld && !err_vld, tag, int'(ip_vld) + int'(err_vld), 0);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check(!ip_vld && !err_vld, tag, int'(ip_vld) + int'(err_vld), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C41F));
    model_clear();
    @(negedge clk);
    do_reset("R1 reset state");

    // R2: no strobe yet, nothing must come out
    for (int i = 0; i < 20; i++) step(1, 0, rnd_smp(), "R2 pre-lock");
    check(!ip_vld && !err_vld, "R2 idle", int'(ip_vld), 0);

    // R3 R4 R5: one strobe, then free-running random chips
    step(1, 1, rnd_smp(), "R3 lock");
    for (int i = 0; i < 8 * 20 - 1; i++) step(1, 0, rnd_smp(), "R3 R4 R5 stream");

    // R10: strobe on every expected chip start
    for (int c = 0; c < 10; c++)
      for (int p = 0; p < 8; p++) step(1, p == 0, rnd_smp(), "R10 aligned strobe");

    // R6: full-scale extremes in both halves
    for (int c = 0; c < 6; c++)
      for (int p = 0; p < 8; p++) step(1, 0, (p < 4) ? 2047 : -2048, "R6 full scale err");
    for (int c = 0; c < 3; c++)
      for (int p = 0; p < 8; p++) step(1, 0, -2048, "R6 full scale ip min");
    for (int c = 0; c < 3; c++)
      for (int p = 0; p < 8; p++) step(1, 0, 2047, "R6 full scale ip max");
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 8; p++) step(1, 0, (p < 4) ? -2048 : 2047, "R6 full scale err neg");

    // R7 R8: random valid gaps, strobes during gaps
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom_range(9) < 7);
      step(v, v ? 1'b0 : ($urandom_range(1) == 1), rnd_smp(), "R7 R8 gaps");
    end

    // R9: mid-chip realignment at various phases
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 8 * 3 + int'($urandom_range(7)); i++) step(1, 0, rnd_smp(), "R9 pre");
      step(1, 1, rnd_smp(), "R9 slip");
      for (int i = 0; i < 8 * 3; i++) step(($urandom_range(4) != 0), 0, rnd_smp(), "R9 post");
    end

    // R11: reset in the middle of a chip
    for (int i = 0; i < 13; i++) step(1, 0, rnd_smp(), "R11 pre");
    do_reset("R11 reset");
    for (int i = 0; i < 16; i++) step(1, 0, rnd_smp(), "R11 no strobe");
    step(1, 1, 100, "R11 relock");
    for (int i = 0; i < 8 * 6 - 1; i++) step(1, 0, rnd_smp(), "R11 first err positive");

    // long random mix
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom_range(7) != 0);
      step(v, ($urandom_range(40) == 0), rnd_smp(), "R3 R4 R5 R9 mix");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule